// File: doc/BRIEF.md
# Radio Control Port Command Decoder

This block is the host-facing serial control port of a small packet radio. It acts as an SPI slave in mode 0: the host pulls chip select low, and the first byte it shifts in is a command. While that command byte travels in on MOSI, the current status byte travels out on MISO. The command then decides what the later bytes of the frame mean. They can be register data to store, dummy bytes that clock register contents out, payload bytes for the transmit queue, or dummy bytes that drain the receive queue. Two commands empty a payload queue, and a no-operation command returns the status byte and nothing else.

On the radio side, two shallow byte queues carry payloads. The radio pushes received bytes through a valid/ready port and takes bytes for transmission through a valid/take port. Three event pulses (packet received, packet sent, retries exhausted) set sticky status flags. The host clears these flags by writing ones to them. An active-low interrupt output is asserted while any flag is set that the configuration register does not mask. The SPI pins are sampled through a synchronizer on the system clock, so the serial clock has to run well below the system clock.

Top module: `radio_ctrl_port`

## Requirements
- R1: The first byte shifted out in every frame is the status byte. Bit 6 is the received flag, bit 5 the sent flag and bit 4 the retry-limit flag. Bits 3:1 read 000 when the receive queue holds data and 111 when it is empty. Bit 0 is set when the transmit queue is full.
- R2: Opcode 000aaaaa reads register aaaaa. Its value is returned in the byte after the command. For single-byte registers, any further bytes return 0x00.
- R3: Opcode 001aaaaa writes the next byte to register aaaaa. The payload width registers 0x11 to 0x16 keep only their low 6 bits. Configuration bit 7 always reads 0.
- R4: After reset the configuration register at 0x00 reads 0x08. Single-byte registers read 0x00 and the interrupt output is high.
- R5: The registers at 0x0A, 0x0B and 0x10 are five bytes wide and transfer least significant byte first. They reset to 0xE7 repeated, 0xC2 repeated and 0xE7 repeated. A partial write changes only the bytes it sends.
- R6: Each status flag is set by its event pulse. It is cleared only by writing a 1 to its bit (6, 5 or 4) of register 0x07. A written 0 leaves the flag unchanged.
- R7: The interrupt output is low exactly while a flag is set whose mask bit in configuration bits 6 (received), 5 (sent) or 4 (retry limit) is 0.
- R8: Opcode 0xA0 queues at most as many of the following bytes as the width at 0x11, and never more than the queue can hold. Bytes beyond either limit are dropped. The radio side receives the queued bytes in order.
- R9: Opcode 0x61 returns received bytes, oldest first, for up to the width at 0x11. After that width, or once the queue is empty, it returns 0x00.
- R10: Opcode 0xE1 empties the transmit queue and 0xE2 empties the receive queue.
- R11: Opcode 0xFF, and any opcode without another meaning, only returns the status byte and changes nothing.
- R12: Register 0x17 is read-only. Bit 0 shows the receive queue empty, bit 1 the receive queue full, bit 4 the transmit queue empty and bit 5 the transmit queue full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| irq_n | output | 1 | Interrupt, active low |
| rx_wr_valid | input | 1 | Radio offers a received byte |
| rx_wr_data | input | 8 | Received byte |
| rx_wr_ready | output | 1 | Receive queue can accept a byte |
| tx_rd_valid | output | 1 | Transmit queue holds a byte |
| tx_rd_data | output | 8 | Oldest transmit byte |
| tx_rd_take | input | 1 | Radio consumes the oldest transmit byte |
| ev_rx_dr | input | 1 | Pulse: packet received |
| ev_tx_ds | input | 1 | Pulse: packet sent |
| ev_max_rt | input | 1 | Pulse: retry limit reached |

## Verification
The bench targets the byte boundaries of a frame. A port that loaded its reply one bit late would shift every returned byte, and one that did not wrap its byte index would misread five-byte address registers. It overfills payload frames beyond the width and beyond queue capacity, so an off-by-one limit would show up as an extra queued or popped byte. It writes zeros to the status register and sets masked flags, which exposes a flag clear that does not honour write-one or an interrupt that ignores its mask. Flushes, writes to the read-only queue register and unknown opcodes are each followed by a readback, so any stray side effect becomes visible at the pins.

// File: rtl/radio_port_pkg.sv
package radio_port_pkg;

    localparam int ADDR_W   = 5;
    localparam int MB_BYTES = 5;
    localparam int MB_REGS  = 3;
    localparam int WID_W    = 6;

    localparam logic [ADDR_W-1:0] A_CONFIG  = 5'h00;
    localparam logic [ADDR_W-1:0] A_STATUS  = 5'h07;
    localparam logic [ADDR_W-1:0] A_ADDR_P0 = 5'h0A;
    localparam logic [ADDR_W-1:0] A_ADDR_P1 = 5'h0B;
    localparam logic [ADDR_W-1:0] A_ADDR_TX = 5'h10;
    localparam logic [ADDR_W-1:0] A_WID_LO  = 5'h11;
    localparam logic [ADDR_W-1:0] A_WID_HI  = 5'h16;
    localparam logic [ADDR_W-1:0] A_QSTAT   = 5'h17;

    localparam logic [7:0] CFG_RESET = 8'h08;

    typedef enum logic [2:0] {
        OP_RD_REG,
        OP_WR_REG,
        OP_RD_RX,
        OP_WR_TX,
        OP_FLUSH_TX,
        OP_FLUSH_RX,
        OP_NOP
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic rx_dr;
        logic tx_ds;
        logic max_rt;
    } flags_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.addr = b[ADDR_W-1:0];
        if (b[7:5] == 3'b000)      c.op = OP_RD_REG;
        else if (b[7:5] == 3'b001) c.op = OP_WR_REG;
        else if (b == 8'h61)       c.op = OP_RD_RX;
        else if (b == 8'hA0)       c.op = OP_WR_TX;
        else if (b == 8'hE1)       c.op = OP_FLUSH_TX;
        else if (b == 8'hE2)       c.op = OP_FLUSH_RX;
        else                       c.op = OP_NOP;
        return c;
    endfunction

    // Index of a five-byte register, or MB_REGS when the address is single-byte.
    function automatic int mb_index(input logic [ADDR_W-1:0] a);
        if (a == A_ADDR_P0) return 0;
        if (a == A_ADDR_P1) return 1;
        if (a == A_ADDR_TX) return 2;
        return MB_REGS;
    endfunction

    function automatic logic [7:0] mb_reset(input int sel);
        return (sel == 1) ? 8'hC2 : 8'hE7;
    endfunction

    function automatic logic [7:0] write_mask(input logic [ADDR_W-1:0] a);
        if (a == A_CONFIG) return 8'h7F;
        if (a >= A_WID_LO && a <= A_WID_HI) return 8'h3F;
        return 8'hFF;
    endfunction

endpackage

// File: rtl/spi_port_frontend.sv
module spi_port_frontend #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csn,
    input  logic       sck,
    input  logic       mosi,
    input  logic [7:0] first_byte,
    input  logic [7:0] next_byte,
    output logic       miso,
    output logic       frame_start,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    // Each stage holds {csn, sck, mosi}.
    logic [2:0] sync_q [SYNC_STAGES];
    logic       csn_s, sck_s, mosi_s;
    logic       csn_d, sck_d;
    logic       sck_rise, sck_fall;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b100;
        end else begin
            sync_q[0] <= {csn, sck, mosi};
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign {csn_s, sck_s, mosi_s} = sync_q[SYNC_STAGES-1];
    assign frame_start = csn_d & ~csn_s;
    assign sck_rise    = ~csn_s & ~sck_d & sck_s;
    assign sck_fall    = ~csn_s & sck_d & ~sck_s;
    assign miso        = tx_sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d     <= 1'b1;
            sck_d     <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            csn_d     <= csn_s;
            sck_d     <= sck_s;
            byte_done <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
                tx_sh   <= first_byte;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh[6:0], mosi_s};
                end
            end else if (sck_fall) begin
                if (bit_cnt == 3'd0) tx_sh <= next_byte;
                else                 tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    // R1: the output bit moves only at a frame start or a falling serial clock
    p_miso_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !sck_fall) |=> $stable(miso));

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= bump(wp);
            if (rd_en) rp <= bump(rp);
            cnt <= cnt + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_data = mem[rp];
    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);
    p_count_bound_r12: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/radio_cmd_core.sv
module radio_cmd_core
    import radio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    input  logic       ev_rx_dr,
    input  logic       ev_tx_ds,
    input  logic       ev_max_rt,
    input  logic       tx_full,
    input  logic       tx_empty,
    input  logic       rx_full,
    input  logic       rx_empty,
    input  logic [7:0] rx_head,
    output logic [7:0] status_byte,
    output logic [7:0] next_byte,
    output logic       tx_push,
    output logic [7:0] tx_push_data,
    output logic       tx_flush,
    output logic       rx_pop,
    output logic       rx_flush,
    output logic       irq_n
);
    localparam int NREG = 1 << ADDR_W;

    logic [7:0]       bank [NREG];
    logic [7:0]       mb   [MB_REGS][MB_BYTES];
    flags_t           flags;
    flags_t           clr;
    cmd_t             cmd_q, dec;
    logic             have_cmd;
    logic [WID_W-1:0] idx;
    logic [WID_W-1:0] width;
    logic             at_cmd, at_data, wr_reg;
    op_e              cur_op;
    logic [ADDR_W-1:0] rd_addr;
    logic [WID_W:0]   rd_k;
    logic [7:0]       rd_val, qstat;
    logic [WID_W:0]   next_slot;

    assign dec       = decode_cmd(rx_byte);
    assign width     = bank[A_WID_LO][WID_W-1:0];
    assign at_cmd    = byte_done & ~have_cmd;
    assign at_data   = byte_done & have_cmd;
    assign cur_op    = at_cmd ? dec.op : cmd_q.op;
    assign wr_reg    = at_data && (cmd_q.op == OP_WR_REG);
    assign next_slot = {1'b0, idx} + (WID_W+1)'(1);

    assign status_byte = {1'b0, flags.rx_dr, flags.tx_ds, flags.max_rt,
                          {3{rx_empty}}, tx_full};
    assign qstat = {2'b00, tx_full, tx_empty, 2'b00, rx_full, rx_empty};

    // Read data for the byte that follows the one just completed.
    always_comb begin
        rd_addr = at_cmd ? dec.addr : cmd_q.addr;
        rd_k    = at_cmd ? '0 : next_slot;
        rd_val  = 8'h00;
        if (rd_addr == A_STATUS) begin
            if (rd_k == '0) rd_val = status_byte;
        end else if (rd_addr == A_QSTAT) begin
            if (rd_k == '0) rd_val = qstat;
        end else if (mb_index(rd_addr) < MB_REGS) begin
            if (rd_k < (WID_W+1)'(MB_BYTES))
                rd_val = mb[mb_index(rd_addr)][rd_k[2:0]];
        end else if (rd_k == '0) begin
            rd_val = bank[rd_addr];
        end
    end

    always_comb begin
        rx_pop = 1'b0;
        if (at_cmd && dec.op == OP_RD_RX)
            rx_pop = (width != '0) && !rx_empty;
        else if (at_data && cmd_q.op == OP_RD_RX)
            rx_pop = (next_slot < {1'b0, width}) && !rx_empty;
    end

    assign tx_push      = at_data && (cmd_q.op == OP_WR_TX) && (idx < width) && !tx_full;
    assign tx_push_data = rx_byte;
    assign tx_flush     = at_cmd && (dec.op == OP_FLUSH_TX);
    assign rx_flush     = at_cmd && (dec.op == OP_FLUSH_RX);

    always_comb begin
        clr = '0;
        if (wr_reg && cmd_q.addr == A_STATUS && idx == '0) clr = rx_byte[6:4];
    end

    assign irq_n = ~((flags.rx_dr  & ~bank[A_CONFIG][6]) |
                     (flags.tx_ds  & ~bank[A_CONFIG][5]) |
                     (flags.max_rt & ~bank[A_CONFIG][4]));

    // Frame tracking and reply selection.
    always_ff @(posedge clk) begin
        if (rst) begin
            have_cmd  <= 1'b0;
            cmd_q     <= '{op: OP_NOP, addr: '0};
            idx       <= '0;
            next_byte <= '0;
        end else if (frame_start) begin
            have_cmd <= 1'b0;
            idx      <= '0;
        end else if (byte_done) begin
            if (!have_cmd) begin
                have_cmd <= 1'b1;
                cmd_q    <= dec;
            end else if (idx != '1) begin
                idx <= idx + WID_W'(1);
            end
            case (cur_op)
                OP_RD_REG: next_byte <= rd_val;
                OP_RD_RX:  next_byte <= rx_pop ? rx_head : 8'h00;
                default:   next_byte <= 8'h00;
            endcase
        end
    end

    // Register storage.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < NREG; a++) bank[a] <= 8'h00;
            bank[A_CONFIG] <= CFG_RESET;
            for (int s = 0; s < MB_REGS; s++)
                for (int b = 0; b < MB_BYTES; b++) mb[s][b] <= mb_reset(s);
        end else if (wr_reg && cmd_q.addr != A_STATUS && cmd_q.addr != A_QSTAT) begin
            if (mb_index(cmd_q.addr) < MB_REGS) begin
                if (idx < WID_W'(MB_BYTES))
                    mb[mb_index(cmd_q.addr)][idx[2:0]] <= rx_byte;
            end else if (idx == '0) begin
                bank[cmd_q.addr] <= rx_byte & write_mask(cmd_q.addr);
            end
        end
    end

    // Sticky flags: an event in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | {ev_rx_dr, ev_tx_ds, ev_max_rt};
    end

    p_w1c_rx_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.rx_dr) |-> $past(wr_reg && cmd_q.addr == A_STATUS && idx == '0 && rx_byte[6]));
    p_w1c_max_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.max_rt) |-> $past(wr_reg && cmd_q.addr == A_STATUS && idx == '0 && rx_byte[4]));
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (bank[A_CONFIG][6] && bank[A_CONFIG][5] && bank[A_CONFIG][4]) |-> irq_n);
    p_cfg_top_bit_r3: assert property (@(posedge clk) disable iff (rst)
        !bank[A_CONFIG][7]);

endmodule

// File: rtl/radio_ctrl_port.sv
module radio_ctrl_port #(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csn,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic       irq_n,
    input  logic       rx_wr_valid,
    input  logic [7:0] rx_wr_data,
    output logic       rx_wr_ready,
    output logic       tx_rd_valid,
    output logic [7:0] tx_rd_data,
    input  logic       tx_rd_take,
    input  logic       ev_rx_dr,
    input  logic       ev_tx_ds,
    input  logic       ev_max_rt
);
    logic       frame_start, byte_done;
    logic [7:0] rx_byte, status_byte, next_byte;
    logic       tx_push, tx_flush, rx_pop, rx_flush;
    logic [7:0] tx_push_data, rx_head;
    logic       tx_full, tx_empty, rx_full, rx_empty;

    spi_port_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .csn(csn), .sck(sck), .mosi(mosi),
        .first_byte(status_byte), .next_byte(next_byte), .miso(miso),
        .frame_start(frame_start), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    radio_cmd_core u_core (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_done(byte_done),
        .rx_byte(rx_byte), .ev_rx_dr(ev_rx_dr), .ev_tx_ds(ev_tx_ds),
        .ev_max_rt(ev_max_rt), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_head(rx_head),
        .status_byte(status_byte), .next_byte(next_byte), .tx_push(tx_push),
        .tx_push_data(tx_push_data), .tx_flush(tx_flush), .rx_pop(rx_pop),
        .rx_flush(rx_flush), .irq_n(irq_n)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush), .wr_en(tx_push),
        .wr_data(tx_push_data), .rd_en(tx_rd_take & ~tx_empty),
        .rd_data(tx_rd_data), .full(tx_full), .empty(tx_empty)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush), .wr_en(rx_wr_valid & ~rx_full),
        .wr_data(rx_wr_data), .rd_en(rx_pop),
        .rd_data(rx_head), .full(rx_full), .empty(rx_empty)
    );

    assign rx_wr_ready = ~rx_full;
    assign tx_rd_valid = ~tx_empty;

endmodule

// File: tb/radio_ctrl_port_test.sv
module radio_ctrl_port_test;
    localparam int DEPTH = 8;
    localparam int HALF  = 6;

    logic clk = 1'b0, rst = 1'b1;
    logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, irq_n, rx_wr_ready, tx_rd_valid;
    logic rx_wr_valid = 1'b0, tx_rd_take = 1'b0;
    logic [7:0] rx_wr_data = 8'h00, tx_rd_data;
    logic ev_rx_dr = 1'b0, ev_tx_ds = 1'b0, ev_max_rt = 1'b0;

    radio_ctrl_port #(.FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .csn(csn), .sck(sck), .mosi(mosi), .miso(miso),
        .irq_n(irq_n), .rx_wr_valid(rx_wr_valid), .rx_wr_data(rx_wr_data),
        .rx_wr_ready(rx_wr_ready), .tx_rd_valid(tx_rd_valid), .tx_rd_data(tx_rd_data),
        .tx_rd_take(tx_rd_take), .ev_rx_dr(ev_rx_dr), .ev_tx_ds(ev_tx_ds),
        .ev_max_rt(ev_max_rt)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, quiet = 0;
    bit finished = 0;

    // Behavioural reference model
    logic [7:0] m_bank [32];
    logic [7:0] m_mb [3][5];
    logic [2:0] m_flags;
    logic [7:0] m_txq [$];
    logic [7:0] m_rxq [$];
    int m_op, m_addr;

    function automatic logic [7:0] m_status();
        return {1'b0, m_flags, (m_rxq.size() == 0) ? 3'b111 : 3'b000, m_txq.size() == DEPTH};
    endfunction
    function automatic logic [7:0] m_qstat();
        return {2'b00, m_txq.size() == DEPTH, m_txq.size() == 0, 2'b00,
                m_rxq.size() == DEPTH, m_rxq.size() == 0};
    endfunction
    function automatic int m_sel(int a);
        return (a == 'h0A) ? 0 : (a == 'h0B) ? 1 : (a == 'h10) ? 2 : -1;
    endfunction
    function automatic logic [7:0] m_read(int a, int k);
        if (a == 'h07) return (k == 0) ? m_status() : 8'h00;
        if (a == 'h17) return (k == 0) ? m_qstat() : 8'h00;
        if (m_sel(a) >= 0) return (k < 5) ? m_mb[m_sel(a)][k] : 8'h00;
        return (k == 0) ? m_bank[a] : 8'h00;
    endfunction
    function automatic int m_width();
        return int'(m_bank['h11][5:0]);
    endfunction

    // op codes of the model: 0 read,1 write,2 rx,3 tx,4 ftx,5 frx,6 nop
    task automatic m_step(input logic [7:0] b, input int pos, output logic [7:0] nxt);
        nxt = 8'h00;
        if (pos == 0) begin
            m_addr = int'(b[4:0]);
            if (b[7:5] == 3'b000) m_op = 0;
            else if (b[7:5] == 3'b001) m_op = 1;
            else if (b == 8'h61) m_op = 2;
            else if (b == 8'hA0) m_op = 3;
            else if (b == 8'hE1) m_op = 4;
            else if (b == 8'hE2) m_op = 5;
            else m_op = 6;
            case (m_op)
                0: nxt = m_read(m_addr, 0);
                2: if (m_width() > 0 && m_rxq.size() > 0) nxt = m_rxq.pop_front();
                4: m_txq.delete();
                5: m_rxq.delete();
                default: ;
            endcase
        end else begin
            int j = pos - 1;
            case (m_op)
                0: nxt = m_read(m_addr, j + 1);
                1: begin
                    if (m_addr == 'h07) begin
                        if (j == 0) m_flags = m_flags & ~b[6:4];
                    end else if (m_addr == 'h17) begin
                    end else if (m_sel(m_addr) >= 0) begin
                        if (j < 5) m_mb[m_sel(m_addr)][j] = b;
                    end else if (j == 0) begin
                        if (m_addr == 0) m_bank[0] = b & 8'h7F;
                        else if (m_addr >= 'h11 && m_addr <= 'h16) m_bank[m_addr] = b & 8'h3F;
                        else m_bank[m_addr] = b;
                    end
                end
                2: if (j + 1 < m_width() && m_rxq.size() > 0) nxt = m_rxq.pop_front();
                3: if (j < m_width() && m_txq.size() < DEPTH) m_txq.push_back(b);
                default: ;
            endcase
        end
    endtask

    function automatic logic m_irq_n();
        return !((m_flags[2] && !m_bank[0][6]) || (m_flags[1] && !m_bank[0][5]) ||
                 (m_flags[0] && !m_bank[0][4]));
    endfunction

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full SPI frame; every returned byte is compared with the model.
    task automatic spi(input logic [7:0] bytes[$], input string tag);
        logic [7:0] exp, got;
        exp = m_status();
        csn = 1'b0;
        clks(HALF);
        foreach (bytes[i]) begin
            got = 8'h00;
            for (int b = 7; b >= 0; b--) begin
                mosi = bytes[i][b];
                clks(HALF);
                got[b] = miso;
                sck = 1'b1;
                clks(HALF);
                sck = 1'b0;
            end
            check8(got, exp, $sformatf("%s byte%0d", tag, i));
            m_step(bytes[i], i, exp);
        end
        clks(HALF);
        csn = 1'b1;
        clks(2 * HALF);
    endtask

    task automatic event_pulse(input int which);
        if (which == 2) ev_rx_dr = 1'b1;
        if (which == 1) ev_tx_ds = 1'b1;
        if (which == 0) ev_max_rt = 1'b1;
        @(posedge clk);
        m_flags[which] = 1'b1;
        @(negedge clk);
        ev_rx_dr = 1'b0; ev_tx_ds = 1'b0; ev_max_rt = 1'b0;
        clks(2);
    endtask

    task automatic rx_push(input logic [7:0] d);
        check8({7'd0, rx_wr_ready}, {7'd0, m_rxq.size() < DEPTH}, "R12 rx ready");
        rx_wr_valid = 1'b1;
        rx_wr_data  = d;
        @(posedge clk);
        if (m_rxq.size() < DEPTH) m_rxq.push_back(d);
        @(negedge clk);
        rx_wr_valid = 1'b0;
    endtask

    task automatic tx_pop();
        check8(tx_rd_data, m_txq[0], "R8 tx data order");
        tx_rd_take = 1'b1;
        @(posedge clk);
        void'(m_txq.pop_front());
        @(negedge clk);
        tx_rd_take = 1'b0;
    endtask

    // Idle-time comparison of the pin-level state against the model.
    always @(negedge clk) begin
        if (rst || !csn) quiet = 0;
        else if (quiet < 100) quiet++;
        if (!finished && !rst && quiet >= 8) begin
            check8({7'd0, irq_n}, {7'd0, m_irq_n()}, "R7 irq");
            check8({7'd0, tx_rd_valid}, {7'd0, m_txq.size() > 0}, "R8 tx valid");
            check8({7'd0, rx_wr_ready}, {7'd0, m_rxq.size() < DEPTH}, "R12 rx ready");
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 32; a++) m_bank[a] = 8'h00;
        m_bank[0] = 8'h08;
        for (int s = 0; s < 3; s++) for (int b = 0; b < 5; b++) m_mb[s][b] = (s == 1) ? 8'hC2 : 8'hE7;
        m_flags = 3'b000;
        clks(5);
        rst = 1'b0;
        clks(10);

        check8({7'd0, irq_n}, 8'h01, "R4 irq after reset");
        spi('{8'hFF}, "R11 nop status");
        spi('{8'h00, 8'hFF, 8'hFF}, "R4 R2 config read");
        check8(m_bank[0], 8'h08, "R4 config model");
        spi('{8'h0A, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R5 pipe0 addr");
        spi('{8'h0B, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R5 pipe1 addr");
        spi('{8'h10, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R5 tx addr");
        spi('{8'h26, 8'h00}, "R3 write 06");
        spi('{8'h06, 8'hFF}, "R2 read 06");
        spi('{8'h26, 8'h0F}, "R3 write 06b");
        spi('{8'h06, 8'hFF, 8'hFF}, "R2 read 06b");
        spi('{8'h31, 8'hFF}, "R3 width write");
        spi('{8'h11, 8'hFF}, "R3 width masked");
        spi('{8'h31, 8'h04}, "R3 width 4");
        spi('{8'h2A, 8'h11, 8'h22, 8'h33}, "R5 partial write");
        spi('{8'h0A, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R5 partial read");
        spi('{8'h20, 8'hFF}, "R3 config write");
        spi('{8'h00, 8'hFF}, "R3 config bit7");
        spi('{8'h20, 8'h08}, "R3 config restore");

        event_pulse(2);
        check8({7'd0, irq_n}, 8'h00, "R7 irq on rx flag");
        spi('{8'hFF}, "R6 flag set");
        spi('{8'h27, 8'h00}, "R6 zero write");
        spi('{8'h07, 8'hFF}, "R6 flag kept");
        spi('{8'h27, 8'h40}, "R6 clear rx");
        check8({7'd0, irq_n}, 8'h01, "R6 irq released");
        spi('{8'h20, 8'h48}, "R7 mask rx");
        event_pulse(2);
        check8({7'd0, irq_n}, 8'h01, "R7 masked rx");
        event_pulse(1);
        event_pulse(0);
        check8({7'd0, irq_n}, 8'h00, "R7 unmasked tx");
        spi('{8'h27, 8'h50}, "R6 clear two");
        spi('{8'hFF}, "R6 one left");
        spi('{8'h27, 8'h70}, "R6 clear all");
        spi('{8'h20, 8'h08}, "R7 unmask");

        spi('{8'hA0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, "R8 tx payload");
        tx_pop(); tx_pop();
        spi('{8'hA0, 8'h11, 8'h12, 8'h13, 8'h14}, "R8 tx fill");
        spi('{8'hA0, 8'h21, 8'h22, 8'h23, 8'h24}, "R8 tx overfill");
        spi('{8'hFF}, "R1 tx full status");
        spi('{8'h17, 8'hFF}, "R12 fifo full");
        tx_pop(); tx_pop(); tx_pop();
        spi('{8'hE1}, "R10 flush tx");
        spi('{8'h17, 8'hFF}, "R12 after tx flush");

        for (int i = 0; i < 5; i++) rx_push(8'h40 + 8'(i));
        spi('{8'hFF}, "R1 rx pipe bits");
        spi('{8'h61, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R9 rx payload");
        for (int i = 0; i < 8; i++) rx_push(8'h80 + 8'(i));
        spi('{8'h17, 8'hFF}, "R12 rx full");
        spi('{8'h37, 8'h00}, "R12 write ignored");
        spi('{8'h17, 8'hFF}, "R12 readback");
        spi('{8'h50, 8'hAA, 8'h55}, "R11 unknown op");
        spi('{8'h61, 8'hFF, 8'hFF}, "R9 rx partial");
        spi('{8'hE2}, "R10 flush rx");
        spi('{8'h61, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R9 rx empty");
        spi('{8'h17, 8'hFF}, "R10 both empty");
        clks(20);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule